// File: doc/BRIEF.md
# Iterative Restoring Divider

This block divides an unsigned double-width dividend by a single-width divisor. It forms one quotient bit per clock with a restoring subtract, shift and test step. The dividend comes in as two words. The upper word goes into a partial-remainder register and the lower word into a shift register that gradually fills with quotient bits. On every step the two registers shift left together as one value, so the top bit of the lower word moves into the bottom bit of the upper word. After one step per quotient bit, the upper register holds the remainder and the lower register holds the quotient.

A start strobe launches a division. It only does so when all of these hold:
- the divisor is non-zero;
- the caller's precondition flag is clear;
- the upper dividend word is smaller than the divisor, so the quotient fits in one word.

If any of these fails, the unit raises an error pulse and does no iteration. The results stay on the outputs until the next accepted division.

Top module: `divstep_unit`

## Requirements
- R1: After reset, busy, done and err are 0, and quo and rem read 0.
- R2: A start accepted while idle raises busy on the next clock edge. Busy stays high for exactly W cycles. Done then pulses high for one cycle, in the same cycle that busy falls.
- R3: When done is high, quo equals floor(({hi_i,lo_i}) / div_i) and rem equals ({hi_i,lo_i}) mod div_i, using the operands sampled with the accepted start. The upper word hi_i forms the most significant W bits.
- R4: A start with div_i equal to 0 raises err for one cycle and does not raise busy.
- R5: A start with flag_i equal to 1 raises err for one cycle and does not raise busy.
- R6: A start with hi_i greater than or equal to div_i raises err for one cycle and does not raise busy. The boundary case hi_i = div_i - 1 is accepted.
- R7: A start pulse while busy is ignored. The running division finishes with its original operands.
- R8: While idle, quo and rem keep their last values. A rejected start leaves them unchanged.
- R9: Whenever done is high, rem is smaller than the divisor in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a division (sampled while idle) |
| div_i | input | W | Divisor |
| hi_i | input | W | Upper word of the dividend |
| lo_i | input | W | Lower word of the dividend |
| flag_i | input | 1 | Precondition flag; must be 0 to start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are ready |
| err | output | 1 | One-cycle pulse when a start is rejected |
| quo | output | W | Quotient (lower register) |
| rem | output | W | Remainder (upper register) |

## Verification
The bench builds the unit at its default W = 16. This makes every operand combination reachable from 32-bit random draws, and the exact W-cycle busy window can be counted directly. Random valid operands are drawn with the upper word constrained below the divisor, so the full quotient range gets exercised. Directed cases cover:
- a divisor of one;
- the largest legal upper word;
- the all-ones divisor;
- each rejection cause, including the equality boundary of the overflow test.

// File: rtl/divstep_unit.sv
module divstep_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] div_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic         flag_i,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  hi_q, lo_q, dv_q;
  logic [CW-1:0] cnt;
  logic          busy_q, done_q, err_q;

  wire         reject = (div_i == '0) | flag_i | (hi_i >= div_i);
  wire [W:0]   trial  = {hi_q, lo_q[W-1]} - {1'b0, dv_q};
  wire         fits   = ~trial[W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      dv_q   <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (busy_q) begin
        hi_q <= fits ? trial[W-1:0] : {hi_q[W-2:0], lo_q[W-1]};
        lo_q <= {lo_q[W-2:0], fits};
        cnt  <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        if (reject) begin
          err_q <= 1'b1;
        end else begin
          hi_q   <= hi_i;
          lo_q   <= lo_i;
          dv_q   <= div_i;
          cnt    <= '0;
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;
  assign quo  = lo_q;
  assign rem  = hi_q;

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R2
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R4
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(start) && !$past(busy) && !busy));

  // R9
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem < dv_q));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$rose(busy)) |-> ($stable(quo) && $stable(rem)));

  // R2
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

// File: tb/divstep_unit_bench.sv
module divstep_unit_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] div_i = '0, hi_i = '0, lo_i = '0;
  logic         flag_i = 1'b0;
  logic         busy, done, err;
  logic [W-1:0] quo, rem;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  divstep_unit #(.W(W)) u_divstep_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .div_i(div_i), .hi_i(hi_i),
    .lo_i(lo_i), .flag_i(flag_i), .busy(busy), .done(done), .err(err),
    .quo(quo), .rem(rem)
  );

  function automatic logic [W-1:0] exp_q(input logic [W-1:0] d, h, l);
    logic [2*W-1:0] n = {h, l};
    return W'(n / {{W{1'b0}}, d});
  endfunction

  function automatic logic [W-1:0] exp_r(input logic [W-1:0] d, h, l);
    logic [2*W-1:0] n = {h, l};
    return W'(n % {{W{1'b0}}, d});
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // valid division; optional stray start while busy (R7)
  task automatic run_ok(input logic [W-1:0] d, h, l, input bit poke);
    int k;
    @(negedge clk);
    div_i = d; hi_i = h; lo_i = l; flag_i = 0; start = 1;
    @(negedge clk);
    start = 0;
    check("R2 busy rise", busy, 1);
    k = 0;
    while (busy && k < 4*W) begin
      k++;
      if (poke && k == 3) begin
        div_i = 1; hi_i = 0; lo_i = ~l; start = 1;
      end else start = 0;
      @(negedge clk);
    end
    start = 0;
    check("R2 busy length", k, W);
    check("R2 done pulse", done, 1);
    check(poke ? "R7 quotient" : "R3 quotient", quo, exp_q(d, h, l));
    check(poke ? "R7 remainder" : "R3 remainder", rem, exp_r(d, h, l));
    @(negedge clk);
    check("R2 done one cycle", done, 0);
    check("R8 hold quo", quo, exp_q(d, h, l));
  endtask

  task automatic run_bad(input string req, input logic [W-1:0] d, h, l, input bit f);
    logic [W-1:0] q0, r0;
    q0 = quo; r0 = rem;
    @(negedge clk);
    div_i = d; hi_i = h; lo_i = l; flag_i = f; start = 1;
    @(negedge clk);
    start = 0; flag_i = 0;
    check({req, " err"}, err, 1);
    check({req, " no busy"}, busy, 0);
    @(negedge clk);
    check({req, " err one cycle"}, err, 0);
    check("R8 quo after reject", quo, q0);
    check("R8 rem after reject", rem, r0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] d, h, l;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 quo", quo, 0);
    check("R1 rem", rem, 0);
    rst_n = 1;

    run_ok(16'd1, 16'd0, 16'hBEEF, 0);
    run_ok(16'd7, 16'd6, 16'hFFFF, 0);
    run_ok(16'hFFFF, 16'hFFFE, 16'hFFFF, 0);
    run_ok(16'h8000, 16'h7FFF, 16'h0001, 0);
    run_ok(16'd300, 16'd299, 16'd0, 0);   // R6 boundary accepted
    run_ok(16'd1234, 16'd77, 16'h5A5A, 1); // R7

    run_bad("R4", 16'd0, 16'd0, 16'd5, 0);
    run_bad("R5", 16'd9, 16'd1, 16'd5, 1);
    run_bad("R6", 16'd9, 16'd9, 16'd5, 0);
    run_bad("R6", 16'd9, 16'hFFFF, 16'd5, 0);

    for (int i = 0; i < 200; i++) begin
      d = W'($urandom) | 16'd1;
      h = W'($urandom % d);
      l = W'($urandom);
      run_ok(d, h, l, (i % 25) == 0);
    end
    finish_run();
  end
endmodule